// File: doc/BRIEF.md
# Sector Tweak Chaining Wrapper for a Block Cipher

This block sits between a stream of 128-bit data units and an external block cipher and turns that cipher into a tweakable, sector-addressed one. When a unit arrives marked as the start of a sector, the wrapper first sends the sector number to the cipher under the tweak key. It keeps the returned value as the running tweak. Every data unit is then masked with the tweak, sent to the cipher under the data key (forward or inverse, picked per unit), and masked again with the same tweak on the way out. After each unit the tweak is multiplied by x in GF(2^128), so unit j of a sector sees the encrypted sector number times x^j.

A sector holds a fixed number of units (32 by default, for 512-byte sectors). When the last unit of a sector completes, the next unit that is not flagged as a sector start continues with the following sector number. The wrapper fetches that sector's tweak by itself. A sector-start flag at any position drops the current chain and restarts it from the supplied number. Only one unit is in flight at a time, so results leave in arrival order.

Top module: `xts_tweak_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, outValid, cipReqValid and inReady are all 0.
- R2: A unit with inFirst set is not accepted until the tweak for sectorNum has been fetched. The fetch request has cipKeySel=1 (tweak key) and cipDecrypt=0, and carries sectorNum in bits [SECT_W-1:0] with zeros above.
- R3: In encrypt mode (inDecrypt=0 at acceptance), the unit is sent with cipKeySel=0 and cipDecrypt=0 as data XOR tweak. The output is the cipher response XOR the same tweak.
- R4: In decrypt mode (inDecrypt=1 at acceptance), the request has cipKeySel=0 and cipDecrypt=1, with the same masking on both sides. Decrypting a sector's ciphertext under the same sector number returns the plaintext, and the mode may change from unit to unit.
- R5: The tweak for unit j of a sector is the fetched value multiplied by x^j. One doubling is a 1-bit left shift of the 128-bit word, with byte 0 in bits [7:0]. When bit 127 is shifted out, 0x87 is XORed into bits [7:0].
- R6: After UNITS units of a sector have completed, an unflagged unit triggers a fetch for sector number + 1 (modulo 2^SECT_W) and restarts at j = 0.
- R7: A unit with inFirst set that arrives in the middle of a sector abandons the current chain, fetches the tweak for the new sectorNum and is processed as j = 0.
- R8: Unflagged units after reset, before any sector start, are chained as sector 0 starting at j = 0.
- R9: At most one unit is in flight. inReady is 0 while a result is offered, results leave in input order, and outValid and outData stay stable until outReady.
- R10: Once cipReqValid is raised, it stays high, with cipReqData, cipKeySel and cipDecrypt unchanged, until cipReqReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input unit valid |
| inReady | output | 1 | Input unit accepted this cycle when inValid is also high |
| inFirst | input | 1 | Unit is the first of a new sector |
| inDecrypt | input | 1 | 1 selects decryption for this unit |
| inData | input | 128 | Data unit |
| sectorNum | input | SECT_W | Sector number used with inFirst |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Result taken |
| outData | output | 128 | Result unit |
| cipReqValid | output | 1 | Cipher request valid |
| cipReqReady | input | 1 | Cipher accepts request |
| cipKeySel | output | 1 | 1 = tweak key, 0 = data key |
| cipDecrypt | output | 1 | 1 = inverse cipher |
| cipReqData | output | 128 | Cipher input block |
| cipRespValid | input | 1 | One-cycle pulse with the cipher result |
| cipRespData | input | 128 | Cipher result |

## Verification
The hardest states to reach from the ports are the sector boundary after the last unit and a restart in the middle of a sector. At the boundary, an unflagged unit must quietly trigger a new tweak fetch for the next sector number. The stimulus drives more than a full sector of unflagged units in a row, including one run that starts at the all-ones sector number so the increment wraps to zero. It also raises the start flag at unit 7 of a live chain. A behavioural cipher answers requests with varying readiness and latency, so stalls on both handshakes and on the result port occur throughout.

// File: rtl/xts_seq_pkg.sv
package xts_seq_pkg;

  localparam int BLK_W = 128;

  // reduction constant for x^128 = x^7 + x^2 + x + 1
  localparam logic [BLK_W-1:0] GF_FEEDBACK = 128'h87;

  // strobes from control to datapath
  typedef struct packed {
    logic takeSector;   // capture sectorNum for a new chain
    logic bumpSector;   // chain finished, advance sector number
    logic reqTweak;     // cipher request carries the sector word
    logic loadTweak;    // cipher returned the encrypted sector number
    logic latchBlock;   // unit accepted, store pre-masked data
    logic latchResult;  // cipher returned data, store post-masked result
    logic stepTweak;    // unit done, multiply tweak by x
  } seqStrobe_t;

  // multiply by x, byte 0 in bits [7:0]
  function automatic logic [BLK_W-1:0] gfDouble(input logic [BLK_W-1:0] t);
    return {t[BLK_W-2:0], 1'b0} ^ (t[BLK_W-1] ? GF_FEEDBACK : '0);
  endfunction

endpackage

// File: rtl/xts_seq_ctrl.sv
module xts_seq_ctrl
  import xts_seq_pkg::*;
#(
  parameter int UNITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inFirst,
  input  logic       inDecrypt,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output logic       cipReqValid,
  input  logic       cipReqReady,
  output logic       cipKeySel,
  output logic       cipDecrypt,
  input  logic       cipRespValid,
  output seqStrobe_t stb
);

  localparam int CNT_W = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam logic [CNT_W-1:0] LAST_UNIT = CNT_W'(UNITS - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_TREQ,
    S_TWAIT,
    S_DREQ,
    S_DWAIT,
    S_OUT
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] unitIdx;
  logic             chainLive;
  logic             freshLoad;
  logic             pendStart;
  logic             dirReg;

  logic acceptOk;
  logic accept;
  logic needLoad;
  logic lastUnit;
  logic outFire;

  always_comb begin
    acceptOk = (state == S_IDLE) && (inFirst ? freshLoad : chainLive);
    accept   = inValid && acceptOk;
    needLoad = (state == S_IDLE) && inValid && !acceptOk;
    lastUnit = (unitIdx == LAST_UNIT);
    outFire  = (state == S_OUT) && outReady;
  end

  always_comb begin
    stb.takeSector  = needLoad && inFirst;
    stb.bumpSector  = outFire && lastUnit;
    stb.reqTweak    = (state == S_TREQ);
    stb.loadTweak   = (state == S_TWAIT) && cipRespValid;
    stb.latchBlock  = accept;
    stb.latchResult = (state == S_DWAIT) && cipRespValid;
    stb.stepTweak   = outFire && !lastUnit;
  end

  assign inReady     = acceptOk;
  assign outValid    = (state == S_OUT);
  assign cipReqValid = (state == S_TREQ) || (state == S_DREQ);
  assign cipKeySel   = (state == S_TREQ);
  assign cipDecrypt  = (state == S_DREQ) && dirReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:  if (needLoad) state <= S_TREQ;
                 else if (accept) state <= S_DREQ;
        S_TREQ:  if (cipReqReady) state <= S_TWAIT;
        S_TWAIT: if (cipRespValid) state <= S_IDLE;
        S_DREQ:  if (cipReqReady) state <= S_DWAIT;
        S_DWAIT: if (cipRespValid) state <= S_OUT;
        S_OUT:   if (outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitIdx   <= '0;
      chainLive <= 1'b0;
      freshLoad <= 1'b0;
      pendStart <= 1'b0;
      dirReg    <= 1'b0;
    end else begin
      if (needLoad) pendStart <= inFirst;

      if (stb.loadTweak)   freshLoad <= pendStart;
      else if (accept)     freshLoad <= 1'b0;

      if (stb.loadTweak)       chainLive <= 1'b1;
      else if (stb.bumpSector) chainLive <= 1'b0;

      if (stb.loadTweak || stb.bumpSector) unitIdx <= '0;
      else if (stb.stepTweak)              unitIdx <= unitIdx + 1'b1;

      if (accept) dirReg <= inDecrypt;
    end
  end

endmodule

// File: rtl/xts_seq_datapath.sv
module xts_seq_datapath
  import xts_seq_pkg::*;
#(
  parameter int SECT_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [BLK_W-1:0]  inData,
  input  logic [SECT_W-1:0] sectorNum,
  input  logic [BLK_W-1:0]  cipRespData,
  output logic [BLK_W-1:0]  cipReqData,
  output logic [BLK_W-1:0]  outData
);

  logic [BLK_W-1:0]  tweakReg;
  logic [SECT_W-1:0] sectorReg;
  logic [BLK_W-1:0]  blkReg;
  logic [BLK_W-1:0]  resReg;
  logic [BLK_W-1:0]  sectorWord;

  generate
    if (SECT_W < BLK_W) begin : g_pad
      assign sectorWord = {{(BLK_W - SECT_W){1'b0}}, sectorReg};
    end else begin : g_full
      assign sectorWord = sectorReg[BLK_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectorReg <= '0;
      tweakReg  <= '0;
      blkReg    <= '0;
      resReg    <= '0;
    end else begin
      if (stb.takeSector)      sectorReg <= sectorNum;
      else if (stb.bumpSector) sectorReg <= sectorReg + 1'b1;

      if (stb.loadTweak)      tweakReg <= cipRespData;
      else if (stb.stepTweak) tweakReg <= gfDouble(tweakReg);

      if (stb.latchBlock)  blkReg <= inData ^ tweakReg;
      if (stb.latchResult) resReg <= cipRespData ^ tweakReg;
    end
  end

  assign cipReqData = stb.reqTweak ? sectorWord : blkReg;
  assign outData    = resReg;

endmodule

// File: rtl/xts_tweak_seq.sv
module xts_tweak_seq
  import xts_seq_pkg::*;
#(
  parameter int SECT_W = 64,
  parameter int UNITS  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inFirst,
  input  logic              inDecrypt,
  input  logic [BLK_W-1:0]  inData,
  input  logic [SECT_W-1:0] sectorNum,
  output logic              outValid,
  input  logic              outReady,
  output logic [BLK_W-1:0]  outData,
  output logic              cipReqValid,
  input  logic              cipReqReady,
  output logic              cipKeySel,
  output logic              cipDecrypt,
  output logic [BLK_W-1:0]  cipReqData,
  input  logic              cipRespValid,
  input  logic [BLK_W-1:0]  cipRespData
);

  seqStrobe_t stb;

  xts_seq_ctrl #(.UNITS(UNITS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inFirst      (inFirst),
    .inDecrypt    (inDecrypt),
    .inReady      (inReady),
    .outValid     (outValid),
    .outReady     (outReady),
    .cipReqValid  (cipReqValid),
    .cipReqReady  (cipReqReady),
    .cipKeySel    (cipKeySel),
    .cipDecrypt   (cipDecrypt),
    .cipRespValid (cipRespValid),
    .stb          (stb)
  );

  xts_seq_datapath #(.SECT_W(SECT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .inData      (inData),
    .sectorNum   (sectorNum),
    .cipRespData (cipRespData),
    .cipReqData  (cipReqData),
    .outData     (outData)
  );

endmodule

// File: rtl/xts_tweak_seq_chk.sv
module xts_tweak_seq_chk #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [BLK_W-1:0] outData,
  input logic             cipReqValid,
  input logic             cipReqReady,
  input logic             cipKeySel,
  input logic             cipDecrypt,
  input logic [BLK_W-1:0] cipReqData
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !cipReqValid && !inReady));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R9
  single_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cipReqValid && !cipReqReady) |=>
      (cipReqValid && $stable(cipReqData) && $stable(cipKeySel) && $stable(cipDecrypt)));

  // R2
  tweak_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cipReqValid && cipKeySel) |-> !cipDecrypt);

endmodule

bind xts_tweak_seq xts_tweak_seq_chk #(.BLK_W(128)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inReady     (inReady),
  .outValid    (outValid),
  .outReady    (outReady),
  .outData     (outData),
  .cipReqValid (cipReqValid),
  .cipReqReady (cipReqReady),
  .cipKeySel   (cipKeySel),
  .cipDecrypt  (cipDecrypt),
  .cipReqData  (cipReqData)
);

// File: tb/xts_tweak_seq_bench.sv
`timescale 1ns/1ps
module xts_tweak_seq_bench;

  localparam int SW = 64;
  localparam logic [127:0] K1 = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  localparam logic [127:0] K2 = 128'h13579BDF2468ACE0FEDCBA9876543210;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic          inValid = 1'b0, inFirst = 1'b0, inDecrypt = 1'b0;
  logic [127:0]  inData = '0;
  logic [SW-1:0] sectorNum = '0;
  logic          inReady, outValid, outReady = 1'b0;
  logic [127:0]  outData;
  logic          cipReqValid, cipKeySel, cipDecrypt;
  logic          cipReqReady = 1'b0, cipRespValid = 1'b0;
  logic [127:0]  cipReqData, cipRespData = '0;

  xts_tweak_seq u_xts_tweak_seq (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inFirst(inFirst), .inDecrypt(inDecrypt), .inData(inData),
    .sectorNum(sectorNum), .outValid(outValid), .outReady(outReady),
    .outData(outData), .cipReqValid(cipReqValid), .cipReqReady(cipReqReady),
    .cipKeySel(cipKeySel), .cipDecrypt(cipDecrypt), .cipReqData(cipReqData),
    .cipRespValid(cipRespValid), .cipRespData(cipRespData)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [127:0]  expQ[$];
  string         tagQ[$];
  logic [SW-1:0] expSect[$];

  function automatic logic [127:0] encF(input logic [127:0] k, input logic [127:0] x);
    logic [127:0] s;
    s = x + k;
    return {s[120:0], s[127:121]};
  endfunction

  function automatic logic [127:0] decF(input logic [127:0] k, input logic [127:0] y);
    return {y[6:0], y[127:7]} - k;
  endfunction

  function automatic logic [127:0] dbl(input logic [127:0] t);
    return {t[126:0], 1'b0} ^ (t[127] ? 128'h87 : 128'h0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural cipher: variable readiness and latency
  initial begin
    int cyc = 0, lat;
    bit stallPend = 1'b0;
    logic [127:0] stallData, capData;
    logic capKey, capDec;
    forever begin
      @(negedge clk);
      cyc++;
      cipReqReady = (cyc % 3) != 1;
      #1;
      if (stallPend)
        chk(cipReqValid && (cipReqData == stallData), "R10 request held", cipReqData, stallData);
      stallPend = cipReqValid && !cipReqReady;
      stallData = cipReqData;
      if (cipReqValid && cipReqReady) begin
        capData = cipReqData; capKey = cipKeySel; capDec = cipDecrypt;
        if (capKey) begin
          if (expSect.size() == 0) chk(1'b0, "R2 unexpected tweak fetch", capData, 0);
          else begin
            logic [SW-1:0] es;
            es = expSect.pop_front();
            chk(capData == {64'b0, es}, "R2 tweak request data", capData, {64'b0, es});
            chk(!capDec, "R2 tweak request forward", {127'b0, capDec}, 0);
          end
        end
        lat = 1 + (cyc % 3);
        @(posedge clk);
        repeat (lat) @(negedge clk);
        cipRespData  = capKey ? encF(K2, capData) : (capDec ? decF(K1, capData) : encF(K1, capData));
        cipRespValid = 1'b1;
        @(negedge clk);
        cipRespValid = 1'b0;
      end
    end
  end

  // result collector with output stalls
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      outReady = (cyc % 4) != 2;
      #1;
      if (outValid && outReady) begin
        chk(!inReady, "R9 no accept while result offered", {127'b0, inReady}, 0);
        if (expQ.size() == 0) chk(1'b0, "R9 unexpected result", outData, 0);
        else begin
          logic [127:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(outData == e, t, outData, e);
        end
      end
    end
  end

  // reference chain state
  logic [SW-1:0] mSect = '0;
  logic [127:0]  mT = '0;
  int            mJ = 0;
  bit            mLive = 1'b0;

  task automatic sendBlk(input logic [127:0] d, input bit first, input logic [SW-1:0] s,
                         input bit decm, input bit useExp, input logic [127:0] expIn,
                         input string tag, output logic [127:0] res);
    logic [127:0] e;
    if (first || !mLive) begin
      if (first) mSect = s;
      expSect.push_back(mSect);
      mT = encF(K2, {64'b0, mSect});
      mJ = 0;
      mLive = 1'b1;
    end
    e = decm ? (mT ^ decF(K1, mT ^ d)) : (mT ^ encF(K1, mT ^ d));
    res = e;
    if (useExp) e = expIn;
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (mJ == 31) begin
      mLive = 1'b0;
      mSect = mSect + 1'b1;
    end else begin
      mT = dbl(mT);
      mJ++;
    end
    @(negedge clk);
    inValid = 1'b1; inFirst = first; sectorNum = s; inDecrypt = decm; inData = d;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0; inFirst = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
  endtask

  logic [127:0] pt[32];
  logic [127:0] ct[32];

  initial begin
    logic [127:0] r;
    repeat (3) @(negedge clk);
    #1;
    chk(!outValid && !cipReqValid && !inReady, "R1 in reset",
        {125'b0, outValid, cipReqValid, inReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!outValid && !cipReqValid && !inReady, "R1 after reset",
        {125'b0, outValid, cipReqValid, inReady}, 0);

    // R8: chain without any start flag
    for (int j = 0; j < 3; j++)
      sendBlk(128'h1111_0000 + 128'(j), 1'b0, '0, 1'b0, 1'b0, '0, "R8 unflagged after reset", r);

    // R3 / R5: full sector 5, encrypt
    for (int j = 0; j < 32; j++) begin
      pt[j] = {32'hA5A5_0000 + 32'(j), 32'h0123_4567, ~32'(j * 977), 32'hDEAD_0000 ^ 32'(j)};
      sendBlk(pt[j], j == 0, 64'd5, 1'b0, 1'b0, '0, (j == 0) ? "R3 first unit" : "R5 unit chain", ct[j]);
    end

    // R6: continue into sector 6 and the first unit of 7
    for (int j = 0; j < 33; j++)
      sendBlk({96'h0, 32'(j)} ^ 128'hF0F0, 1'b0, 64'd999, 1'b0, 1'b0, '0, "R6 automatic next sector", r);

    // R4: round trip of sector 5
    for (int j = 0; j < 32; j++)
      sendBlk(ct[j], j == 0, 64'd5, 1'b1, 1'b1, pt[j], "R4 round trip", r);

    // R7: abort after 7 units of sector 100
    for (int j = 0; j < 7; j++)
      sendBlk(128'hC0DE_0000 + 128'(j), j == 0, 64'd100, 1'b0, 1'b0, '0, "R5 partial sector", r);
    for (int j = 0; j < 34; j++)
      sendBlk(128'hBEEF_0000 + 128'(j), j == 0, {SW{1'b1}}, 1'b0, 1'b0, '0,
              (j == 0) ? "R7 restart mid sector" : ((j >= 32) ? "R6 sector wrap" : "R5 unit chain"), r);

    // R4: alternating direction inside one sector
    for (int j = 0; j < 10; j++)
      sendBlk(128'h5A5A_0000 + 128'(j * 3), j == 0, 64'd9, j[0], 1'b0, '0, "R4 mixed direction", r);

    repeat (10) @(negedge clk);
    chk(expSect.size() == 0, "R2 all tweak fetches seen", 128'(expSect.size()), 0);
    chk(expQ.size() == 0, "R9 all results seen", 128'(expQ.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R9 watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule